// File: doc/BRIEF.md
# Glitchless Two-Source Clock Multiplexer with Forced Takeover

The block selects one of two free-running input clocks and drives a single output clock. In normal operation a change of the select input is handled by a break-before-make handshake. The old source is disabled on one of its own falling edges, so its last high phase is never cut short. The new source arms only after the old one is seen as off. Its enable is synchronised into the new domain and goes high on a falling edge, so the output resumes on a rising edge of the new clock with a full-width first pulse.

A normal handover needs the old clock to keep running, because only the old clock can clock its enable low. A force input covers the case where the old clock has stopped. While force is raised, both source enables are cleared at once without any clock. Each domain then re-arms only after one falling edge of its own clock, so a stopped input stays disabled for as long as force is held, and activity on the deselected input cannot reach the output. To change source in force mode, lower force, change the select input, then raise force again.

An active-high output enable gates the output. It is sampled on falling edges of the multiplexed clock, so a disable or enable never truncates a pulse. The power-down input acts as an asynchronous clear of the whole block: the output goes LOW at once, and operation restarts through the normal arming sequence when power-down is released. The block carries clocks and has no data stream, so all of its pins are plain level controls. The select input must be held stable for several cycles of both clocks between changes.

Top module: `gcm_glitchless_mux`

## Requirements
- R1: While rst_n is low, clk_out is LOW. After release, clk_out follows the source named by sel (0 = clk_a, 1 = clk_b).
- R2: At most one source enable is high at any time. While one source runs, clk_out has exactly that source's period and high time.
- R3: After sel changes, the last high pulse of the old source ends on an old-clock falling edge within 3 old-clock periods of the change.
- R4: No runt pulse is produced by a normal switch. After the park, clk_out resumes on a rising edge of the new clock within 3 new-clock periods, and its first high phase is a full high phase of the new clock. A source enable rises only while the other enable is low.
- R5: A rising force_sel drives clk_out LOW immediately, even if the old clock has stopped in its high phase.
- R6: While force_sel is held high, clk_out restarts on the clock named by sel within SYNC_STAGES+2 periods of that clock, whether or not the other clock runs.
- R7: While force_sel is high, starting or stopping the deselected clock leaves clk_out unchanged in period and pulse width.
- R8: In force mode, the sequence "lower force_sel, change sel, raise force_sel" drives clk_out LOW at once and restarts it on the newly named clock. Lowering force_sel does not disturb a running output.
- R9: When out_en goes low, at most one further full high pulse appears and clk_out then stays LOW with no truncated pulse. When out_en returns high, full pulses resume.
- R10: When pwr_dn is high, clk_out is LOW immediately and stays LOW. After release, clk_out restarts on the source named by sel through the normal arming sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Source clock 0 |
| clk_b | input | 1 | Source clock 1 |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Source choice: 0 picks clk_a, 1 picks clk_b |
| force_sel | input | 1 | Forced takeover; held high to escape a stopped source |
| out_en | input | 1 | Active-high output enable, applied on output falling edges |
| pwr_dn | input | 1 | Power-down; clears the block and holds the output LOW |
| clk_out | output | 1 | Multiplexed output clock |

## Verification
The hardest state to reach from the ports is a source that stops while the output is high and that source is still enabled. In that state the normal handover can never finish and the output is frozen high. The bench reaches it by halting one clock generator right after one of its rising edges and then changing sel. It first confirms that the output stays frozen, then raises force_sel and checks that the output falls within the same nanosecond and restarts on the live clock. The normal handover is swept over every whole-nanosecond phase of the select change in both directions, and the output-enable drop is swept over every phase of the output period. Each pulse width, park delay and restart delay is compared with bounds derived from the two clock periods.

// File: rtl/gcm_pkg.sv
`timescale 1ns/1ps
package gcm_pkg;
  localparam int NUM_SRC    = 2;
  localparam int MIN_STAGES = 1;

  typedef enum logic {
    SRC_A = 1'b0,
    SRC_B = 1'b1
  } src_e;

  function automatic logic src_is(input logic sel, input src_e who);
    return (src_e'(sel) == who);
  endfunction
endpackage

// File: rtl/gcm_sync.sv
`timescale 1ns/1ps
// Falling-edge synchroniser with asynchronous clear.
module gcm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_in,
  input  logic clr,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(negedge clk_in or posedge clr) begin
        if (clr) stg <= '0;
        else     stg <= d;
      end
    end else begin : g_chain
      always_ff @(negedge clk_in or posedge clr) begin
        if (clr) stg <= '0;
        else     stg <= {stg[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gcm_leg.sv
`timescale 1ns/1ps
// One source domain: request gating, priming after force, enable sync, gate.
module gcm_leg
  import gcm_pkg::*;
#(
  parameter int STAGES = 2,
  parameter int IDX    = 0
) (
  input  logic clk_in,
  input  logic arst,
  input  logic force_sel,
  input  logic sel,
  input  logic other_en,
  output logic en,
  output logic gated
);
  localparam src_e ME = (IDX == 0) ? SRC_A : SRC_B;
  localparam int   CW = $clog2(STAGES + 2);

  logic wanted;
  logic req;
  logic primed;
  logic prime_clr;
  logic chain_clr;

  assign wanted = src_is(sel, ME);

  // Primed flag: cleared whenever force is low; set by the first own falling
  // edge once force is high. Until then the enable chain is held clear.
  assign prime_clr = arst | ~force_sel;

  always_ff @(negedge clk_in or posedge prime_clr) begin
    if (prime_clr) primed <= 1'b0;
    else           primed <= 1'b1;
  end

  assign chain_clr = arst | (force_sel & ~primed);

  // Break-before-make: arm only while the other source is off.
  assign req = wanted & ~other_en;

  gcm_sync #(.STAGES(STAGES)) u_sync (
    .clk_in (clk_in),
    .clr    (chain_clr),
    .d      (req),
    .q      (en)
  );

  // en only changes on a falling edge, while clk_in is low.
  assign gated = clk_in & en;

  // Count own falling edges spent enabled after deselection.
  logic [CW-1:0] drain_cnt;

  always_ff @(negedge clk_in or posedge chain_clr) begin
    if (chain_clr) begin
      drain_cnt <= '0;
    end else if (en && !wanted) begin
      if (drain_cnt != {CW{1'b1}}) drain_cnt <= drain_cnt + CW'(1);
    end else begin
      drain_cnt <= '0;
    end
  end

  // R3: a deselected source drops within STAGES of its own falling edges.
  p_park_bound_r3: assert property (@(negedge clk_in) disable iff (chain_clr)
    drain_cnt <= CW'(STAGES))
    else $error("p_park_bound_r3: source %0d drained too slowly", IDX);

  // R4: an enable comes up only while the other source is off.
  p_arm_break_r4: assert property (@(negedge clk_in) disable iff (chain_clr)
    $rose(en) |-> !other_en)
    else $error("p_arm_break_r4: source %0d armed over the other", IDX);
endmodule

// File: rtl/gcm_out_stage.sv
`timescale 1ns/1ps
// Output enable, applied on falling edges of the multiplexed clock.
module gcm_out_stage (
  input  logic mix_raw,
  input  logic arst,
  input  logic out_en,
  output logic clk_out
);
  logic oe_q;

  always_ff @(negedge mix_raw or posedge arst) begin
    if (arst) oe_q <= 1'b0;
    else      oe_q <= out_en;
  end

  assign clk_out = mix_raw & oe_q;
endmodule

// File: rtl/gcm_glitchless_mux.sv
`timescale 1ns/1ps
module gcm_glitchless_mux
  import gcm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_a,
  input  logic clk_b,
  input  logic rst_n,
  input  logic sel,
  input  logic force_sel,
  input  logic out_en,
  input  logic pwr_dn,
  output logic clk_out
);
  logic                arst;
  logic [NUM_SRC-1:0]  clk_src;
  logic [NUM_SRC-1:0]  en_vec;
  logic [NUM_SRC-1:0]  gated_vec;
  logic                mix_raw;

  // Power-down clears the block exactly as reset does.
  assign arst    = ~rst_n | pwr_dn;
  assign clk_src = {clk_b, clk_a};

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_leg
      gcm_leg #(
        .STAGES (SYNC_STAGES),
        .IDX    (g)
      ) u_leg (
        .clk_in    (clk_src[g]),
        .arst      (arst),
        .force_sel (force_sel),
        .sel       (sel),
        .other_en  (en_vec[NUM_SRC-1-g]),
        .en        (en_vec[g]),
        .gated     (gated_vec[g])
      );
    end
  endgenerate

  assign mix_raw = |gated_vec;

  gcm_out_stage u_out (
    .mix_raw (mix_raw),
    .arst    (arst),
    .out_en  (out_en),
    .clk_out (clk_out)
  );

  // R2: never two sources enabled, seen from either domain.
  p_single_src_a_r2: assert property (@(negedge clk_a) disable iff (arst)
    $onehot0(en_vec))
    else $error("p_single_src_a_r2: both sources enabled");

  p_single_src_b_r2: assert property (@(negedge clk_b) disable iff (arst)
    $onehot0(en_vec))
    else $error("p_single_src_b_r2: both sources enabled");

  // R5: the output is low by the first clk_a edge after force rises.
  p_force_low_r5: assert property (@(posedge clk_a) disable iff (arst)
    $rose(force_sel) |-> !clk_out)
    else $error("p_force_low_r5: output high after force");

  // R10: no output pulse while powered down.
  p_pd_low_r10: assert property (@(posedge clk_b) disable iff (!rst_n)
    pwr_dn |-> !clk_out)
    else $error("p_pd_low_r10: output active in power-down");
endmodule

// File: tb/gcm_glitchless_mux_tb.sv
`timescale 1ns/1ps
module gcm_glitchless_mux_tb_top;
  localparam real PA = 10.0;   // clk_a period, 100 MHz
  localparam real PB = 16.0;   // clk_b period
  localparam int  STG = 2;

  logic clk_a = 1'b0, clk_b = 1'b0;
  logic run_a = 1'b1, run_b = 1'b1;
  logic rst_n = 1'b0, sel = 1'b0, force_sel = 1'b0, out_en = 1'b0, pwr_dn = 1'b0;
  logic clk_out;

  int checks = 0, errors = 0;
  real last_rise = 0.0, last_fall = 0.0, last_period = 0.0, last_high = 0.0;
  real resume_t = 0.0, park_t = 0.0, first_high = 0.0;
  bit  have_rise = 0, have_fall = 0, resume_seen = 0, first_pending = 0, allow_runt = 0;
  int  runt_cnt = 0, rise_cnt = 0;

  gcm_glitchless_mux #(.SYNC_STAGES(STG)) dut_i (
    .clk_a, .clk_b, .rst_n, .sel, .force_sel, .out_en, .pwr_dn, .clk_out
  );

  initial forever begin #(PA/2); if (run_a) clk_a = ~clk_a; end
  initial forever begin #(PB/2); if (run_b) clk_b = ~clk_b; end

  function automatic bit near(input real x, input real y);
    return (x - y < 0.01) && (y - x < 0.01);
  endfunction

  // Output edge monitor
  always @(posedge clk_out) begin
    if (have_rise) last_period = $realtime - last_rise;
    if (have_fall && ($realtime - last_fall > PB/2 + 0.5)) begin
      resume_seen   = 1;
      resume_t      = $realtime;
      park_t        = last_fall;
      first_pending = 1;
    end
    last_rise = $realtime;
    have_rise = 1;
    rise_cnt++;
  end

  always @(negedge clk_out) begin
    if (have_rise) begin
      last_high = $realtime - last_rise;
      if (!allow_runt && !(near(last_high, PA/2) || near(last_high, PB/2))) runt_cnt++;
      if (first_pending) begin
        first_high    = last_high;
        first_pending = 0;
      end
    end
    last_fall = $realtime;
    have_fall = 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input real act, input real exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0.2f expected=%0.2f", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // Normal switch at a chosen phase of the currently running clock.
  task automatic sweep_switch(input logic to_b, input int off);
    real t_sw, old_p, new_p;
    old_p = to_b ? PA : PB;
    new_p = to_b ? PB : PA;
    if (to_b) @(posedge clk_a); else @(posedge clk_b);
    #(off + 0.5);
    runt_cnt    = 0;
    resume_seen = 0;
    t_sw        = $realtime;
    sel         = to_b;
    #250;
    chk(resume_seen, "R4", "output resumed after switch", resume_seen, 1);
    chk(park_t > t_sw && park_t - t_sw <= 3.0 * old_p, "R3", "park delay",
        park_t - t_sw, 3.0 * old_p);
    chk(resume_t - park_t <= 3.0 * new_p, "R4", "hold-off on new clock",
        resume_t - park_t, 3.0 * new_p);
    chk(near(first_high, new_p / 2.0), "R4", "first high phase width",
        first_high, new_p / 2.0);
    chk(runt_cnt == 0, "R4", "runt pulses during switch", runt_cnt, 0);
    chk(near(last_period, new_p), "R2", "period after switch", last_period, new_p);
    chk(near(last_high, new_p / 2.0), "R2", "high time after switch",
        last_high, new_p / 2.0);
  endtask

  initial begin
    real t_f;
    int  n;

    // R1: reset state
    #23;
    chk(clk_out === 1'b0, "R1", "output in reset", clk_out, 0);
    out_en = 1'b1;
    #20;
    chk(clk_out === 1'b0, "R1", "output in reset with enable", clk_out, 0);
    chk(rise_cnt == 0, "R1", "edges during reset", rise_cnt, 0);
    rst_n = 1'b1;
    #250;
    chk(near(last_period, PA), "R1", "period on clk_a after reset", last_period, PA);
    chk(near(last_high, PA / 2.0), "R2", "high time on clk_a", last_high, PA / 2.0);

    // R3/R4: every phase, both directions
    for (int off = 0; off < 16; off++) begin
      sweep_switch(1'b1, off % 10);
      sweep_switch(1'b0, off);
    end

    // R5/R6: clk_b stops high while enabled, then sel moves to clk_a
    sweep_switch(1'b1, 3);
    @(posedge clk_b);
    run_b = 1'b0;
    #3.3;
    n   = rise_cnt;
    sel = 1'b0;
    #100;
    chk(rise_cnt == n, "R5", "normal handover blocked by dead clock", rise_cnt - n, 0);
    chk(clk_out === 1'b1, "R5", "output frozen high before force", clk_out, 1);
    allow_runt  = 1;
    resume_seen = 0;
    t_f         = $realtime;
    force_sel   = 1'b1;
    #0.5;
    chk(clk_out === 1'b0, "R5", "output low at once after force", clk_out, 0);
    #150;
    chk(resume_seen && (resume_t - t_f <= (STG + 2) * PA), "R6", "restart delay in force",
        resume_t - t_f, (STG + 2) * PA);
    chk(near(last_period, PA), "R6", "period after forced restart", last_period, PA);
    allow_runt = 0;
    runt_cnt   = 0;

    // R7: deselected clock wakes up and stops again under force
    n     = rise_cnt;
    run_b = 1'b1;
    #200;
    chk(runt_cnt == 0, "R7", "runts while clk_b restarts", runt_cnt, 0);
    chk(near(last_period, PA), "R7", "period while clk_b runs", last_period, PA);
    chk(rise_cnt - n >= 19 && rise_cnt - n <= 21, "R7", "pulse count over 200 ns",
        rise_cnt - n, 20);
    @(posedge clk_b);
    run_b = 1'b0;
    n     = rise_cnt;
    #200;
    chk(runt_cnt == 0, "R7", "runts while clk_b stops", runt_cnt, 0);
    chk(rise_cnt - n >= 19 && rise_cnt - n <= 21, "R7", "pulse count with clk_b dead",
        rise_cnt - n, 20);
    run_b = 1'b1;

    // R8: leave force, change sel, re-enter force
    @(posedge clk_a);
    #2.5;
    force_sel = 1'b0;
    #100;
    chk(runt_cnt == 0, "R8", "runts after force released", runt_cnt, 0);
    chk(near(last_period, PA), "R8", "period after force released", last_period, PA);
    sel = 1'b1;
    #2;
    allow_runt  = 1;
    resume_seen = 0;
    t_f         = $realtime;
    force_sel   = 1'b1;
    #0.5;
    chk(clk_out === 1'b0, "R8", "output low on force re-entry", clk_out, 0);
    #200;
    chk(resume_seen && (resume_t - t_f <= (STG + 2) * PB), "R8", "restart on clk_b",
        resume_t - t_f, (STG + 2) * PB);
    chk(near(last_period, PB), "R8", "period on clk_b in force", last_period, PB);
    allow_runt = 0;
    runt_cnt   = 0;
    force_sel  = 1'b0;
    #150;
    chk(runt_cnt == 0, "R8", "runts after second release", runt_cnt, 0);
    chk(near(last_period, PB), "R8", "period after second release", last_period, PB);

    // R9: output enable at every phase of the output period
    for (int off = 0; off < 16; off++) begin
      @(posedge clk_b);
      #(off + 0.5);
      n        = rise_cnt;
      runt_cnt = 0;
      out_en   = 1'b0;
      #80;
      chk(rise_cnt - n <= 1, "R9", "pulses after disable", rise_cnt - n, 1);
      chk(clk_out === 1'b0, "R9", "output held low", clk_out, 0);
      chk(runt_cnt == 0, "R9", "truncated pulse on disable", runt_cnt, 0);
      out_en = 1'b1;
      #80;
      chk(runt_cnt == 0, "R9", "truncated pulse on enable", runt_cnt, 0);
      chk(near(last_period, PB), "R9", "period after enable", last_period, PB);
    end

    // R10: power-down in the middle of a high phase
    @(posedge clk_b);
    #2.5;
    allow_runt = 1;
    pwr_dn     = 1'b1;
    #0.5;
    chk(clk_out === 1'b0, "R10", "output low at power-down", clk_out, 0);
    n = rise_cnt;
    #200;
    chk(rise_cnt == n, "R10", "edges during power-down", rise_cnt - n, 0);
    pwr_dn     = 1'b0;
    allow_runt = 0;
    runt_cnt   = 0;
    #250;
    chk(runt_cnt == 0, "R10", "runts after power-up", runt_cnt, 0);
    chk(near(last_period, PB), "R10", "period after power-up", last_period, PB);

    summary();
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    summary();
    $finish;
  end
endmodule